// File: doc/BRIEF.md
# Converter Transition Sweep Linearity Engine

This block runs the digital side of a static linearity test on an N-bit converter. After a `go` pulse it asks an external transition-search engine for each code transition in turn, from target 1 up to target 2^N−1. For every target the search engine servos a high-resolution stimulus until the converter returns the two neighbouring codes equally often, and it hands back that 50% level as an unsigned L-bit stimulus code. The block stores every level in an internal table.

After the last level arrives, the block takes the span between the first and the last transition as the end-point reference line. This removes offset and gain error. The ideal LSB is that span divided by 2^N−2. A second pass then streams, in ascending code order, the differential and integral nonlinearity of each code as signed Q8.8 values in LSBs, under a valid/ready handshake. When the pass is over, the block raises a finished flag and reports the largest DNL and INL magnitudes it has seen.

Top module: `lin_sweep`

## Requirements
- R1: After reset `srch_start`, `res_valid` and `sweep_done` are low and `max_dnl`/`max_inl` are 0.
- R2: A `go` seen while idle or finished produces a one-cycle `srch_start` in the next cycle with `srch_target` = 1. Each `srch_done` seen while waiting produces the next one-cycle `srch_start` in the following cycle, with the target one higher. This continues up to target 2^N−1.
- R3: A `go` during the sweep or during the result pass has no effect on targets, results or timing.
- R4: In the cycle after `srch_done` for target 2^N−1, `res_valid` rises with `res_code` = 1. Codes 1 to 2^N−2 follow in ascending order. Each result is held unchanged until it is accepted by `res_valid && res_ready`.
- R5: Let V[k] be the level returned for target k and S = V[2^N−1] − V[1]. For code D, `res_dnl` = trunc((V[D+1]−V[D])·(2^N−2)·256 / S) − 256, in two's complement Q8.8, where trunc rounds toward zero.
- R6: `res_inl` = trunc((V[D]−V[1])·(2^N−2)·256 / S) − (D−1)·256, in Q8.8.
- R7: A DNL or INL value above 32767 is reported as 32767 (0x7FFF). A value below −32768 is reported as −32768 (0x8000).
- R8: If S ≤ 0, every `res_dnl` and `res_inl` of that pass is 0x8000.
- R9: `sweep_done` rises in the cycle after the last result is accepted and stays high until the next `go`. While it is high, `max_dnl` and `max_inl` hold the largest magnitude of the DNL and INL values streamed in that pass, with −32768 counted as 32767. A new `go` clears both.
- R10: Levels are taken as unsigned over the full L-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a sweep (accepted when idle or finished) |
| srch_start | output | 1 | One-cycle request to the search engine |
| srch_target | output | N | Transition being searched (upper code of the pair) |
| srch_done | input | 1 | Search engine has a level for the current target |
| srch_level | input | L | Measured 50% level, unsigned stimulus code |
| res_valid | output | 1 | Result on res_* is valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_code | output | N | Code of the current result |
| res_dnl | output | 16 | DNL of res_code, signed Q8.8 LSB |
| res_inl | output | 16 | INL of res_code, signed Q8.8 LSB |
| sweep_done | output | 1 | Sweep and result pass finished |
| max_dnl | output | 16 | Largest DNL magnitude, Q8.8 |
| max_inl | output | 16 | Largest INL magnitude, Q8.8 |

## Verification
The stimulus-to-result latencies are fixed at the ports:
- `srch_start` comes one cycle after an accepted `go` or a `srch_done`.
- `res_valid` rises one cycle after the final `srch_done`. Its values are computed with no further delay from the stored table.
- `sweep_done` follows the last accepted result by one cycle.

The bench drives inputs one nanosecond after the rising edge and samples every output on the falling edge. A behavioural phase model, advanced from the inputs seen on that same falling edge, predicts each output for the following cycle. Search latencies vary between one and three cycles, and `res_ready` is throttled in several patterns, so that every handshake path is exercised.

// File: rtl/lin_sweep.sv
module lin_sweep #(
  parameter int N = 8,
  parameter int L = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  output logic                srch_start,
  output logic [N-1:0]        srch_target,
  input  logic                srch_done,
  input  logic [L-1:0]        srch_level,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [N-1:0]        res_code,
  output logic signed [15:0]  res_dnl,
  output logic signed [15:0]  res_inl,
  output logic                sweep_done,
  output logic [15:0]         max_dnl,
  output logic [15:0]         max_inl
);
  localparam int T = (1 << N) - 1;
  localparam int M = T - 1;
  localparam int W = L + N + 10;
  localparam logic signed [W-1:0] SCALE = W'(M * 256);
  localparam logic signed [W-1:0] ONE = W'(256);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_EMIT, S_FIN} st_t;
  st_t st;

  logic [L-1:0]       lvl [1 << N];
  logic [N-1:0]       idx;
  logic signed [L:0]  span;

  function automatic logic signed [15:0] sat(input logic signed [W-1:0] v);
    if (v > 32767)       return 16'sh7fff;
    else if (v < -32768) return 16'sh8000;
    else                 return v[15:0];
  endfunction

  function automatic logic [15:0] mag(input logic signed [15:0] v);
    if (v == 16'sh8000) return 16'h7fff;
    return v[15] ? 16'(-v) : v;
  endfunction

  logic signed [L:0]   step, off;
  logic signed [W-1:0] dvs, q_d, q_o, dnl_w, inl_w;

  assign step  = $signed({1'b0, lvl[idx]}) - $signed({1'b0, lvl[idx - 1'b1]});
  assign off   = $signed({1'b0, lvl[idx - 1'b1]}) - $signed({1'b0, lvl[0]});
  assign dvs   = (span > 0) ? $signed(W'(span)) : $signed(W'(1));
  assign q_d   = ($signed(W'(step)) * SCALE) / dvs;
  assign q_o   = ($signed(W'(off)) * SCALE) / dvs;
  assign dnl_w = q_d - ONE;
  assign inl_w = q_o - ($signed(W'({1'b0, idx})) - $signed(W'(1))) * ONE;

  assign srch_start  = (st == S_ISSUE);
  assign srch_target = idx;
  assign res_valid   = (st == S_EMIT);
  assign res_code    = idx;
  assign res_dnl     = (span > 0) ? sat(dnl_w) : 16'sh8000;
  assign res_inl     = (span > 0) ? sat(inl_w) : 16'sh8000;
  assign sweep_done  = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      span    <= '0;
      max_dnl <= '0;
      max_inl <= '0;
    end else begin
      case (st)
        S_IDLE, S_FIN: if (go) begin
          st      <= S_ISSUE;
          idx     <= N'(1);
          max_dnl <= '0;
          max_inl <= '0;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (srch_done) begin
          lvl[idx - 1'b1] <= srch_level;
          if (idx == N'(T)) begin
            span <= $signed({1'b0, srch_level}) - $signed({1'b0, lvl[0]});
            idx  <= N'(1);
            st   <= S_EMIT;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_ISSUE;
          end
        end
        S_EMIT: if (res_ready) begin
          if (mag(res_dnl) > max_dnl) max_dnl <= mag(res_dnl);
          if (mag(res_inl) > max_inl) max_inl <= mag(res_inl);
          if (idx == N'(M)) st <= S_FIN;
          else              idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srch_start |=> !srch_start);
  p_target_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    srch_start |-> srch_target != '0);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_dnl) && $stable(res_inl));
  p_code_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && res_code != N'(M) |=> res_valid && res_code == $past(res_code) + 1'b1);
  p_first_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> res_code == N'(1));
  p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> !res_valid && !srch_start);
  p_max_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done && !go |=> sweep_done && $stable(max_dnl) && $stable(max_inl));
endmodule

// File: tb/lin_sweep_bench.sv
module lin_sweep_bench;
  localparam int N = 8;
  localparam int L = 16;
  localparam int T = 255;
  localparam int M = 254;

  logic clk = 0, rst_n = 0, go = 0, srch_done = 0, res_ready = 0;
  logic [L-1:0] srch_level = '0;
  logic srch_start, res_valid, sweep_done;
  logic [N-1:0] srch_target, res_code;
  logic signed [15:0] res_dnl, res_inl;
  logic [15:0] max_dnl, max_inl;

  int lv [256];
  int total = 0, bad = 0, rmode = 0;
  longint cyc = 0;

  lin_sweep #(.N(N), .L(L)) u_lin_sweep (
    .clk(clk), .rst_n(rst_n), .go(go), .srch_start(srch_start), .srch_target(srch_target),
    .srch_done(srch_done), .srch_level(srch_level), .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_dnl(res_dnl), .res_inl(res_inl), .sweep_done(sweep_done),
    .max_dnl(max_dnl), .max_inl(max_inl));

  always #10 clk = ~clk;

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic longint span();
    return longint'(lv[T]) - longint'(lv[1]);
  endfunction
  function automatic longint edn(int d);
    if (span() <= 0) return -32768;
    return sat(((longint'(lv[d+1]) - lv[d]) * M * 256) / span() - 256);
  endfunction
  function automatic longint ein(int d);
    if (span() <= 0) return -32768;
    return sat(((longint'(lv[d]) - lv[1]) * M * 256) / span() - longint'(d - 1) * 256);
  endfunction
  function automatic longint mag(longint v);
    if (v == -32768) return 32767;
    return (v < 0) ? -v : v;
  endfunction
  function automatic string tag_of(longint e, string base);
    if (span() <= 0) return "R8";
    if (e == 32767 || e == -32768) return "R7";
    return base;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural phase model, compared on every falling edge
  initial begin
    int phase = 0, et = 1, er = 1;
    bit es = 0;
    longint mxd = 0, mxi = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        $display("FAIL R2 watchdog actual=%0d expected<150000", cyc);
        finish_up();
      end
      if (rst_n) begin
        chk(phase == 0 ? "R1" : "R2", srch_start, es);
        if (srch_start) chk("R2", srch_target, et);
        chk(phase == 0 ? "R1" : "R4", res_valid, phase == 2);
        if (res_valid) begin
          chk("R4", res_code, er);
          chk(tag_of(edn(er), "R5/R10"), res_dnl, edn(er));
          chk(tag_of(ein(er), "R6"), res_inl, ein(er));
        end
        chk(phase == 0 ? "R1" : "R9", sweep_done, phase == 3);
        if (phase == 0) begin chk("R1", max_dnl, 0); chk("R1", max_inl, 0); end
        if (phase == 1) begin chk("R9", max_dnl, 0); chk("R9", max_inl, 0); end
        if (phase == 3) begin chk("R9", max_dnl, mxd); chk("R9", max_inl, mxi); end
        // advance model
        es = 0;
        if ((phase == 0 || phase == 3) && go) begin
          phase = 1; es = 1; et = 1; er = 1; mxd = 0; mxi = 0;
        end else if (phase == 1 && srch_done && !srch_start) begin
          if (et == T) phase = 2;
          else begin et++; es = 1; end
        end else if (phase == 2 && res_ready) begin
          if (mag(edn(er)) > mxd) mxd = mag(edn(er));
          if (mag(ein(er)) > mxi) mxi = mag(ein(er));
          if (er == M) phase = 3; else er++;
        end
      end
    end
  end

  // search-engine responder: latency 1..3 cycles by target
  initial begin
    int cnt = 0, tg = 0;
    forever begin
      @(posedge clk); #1;
      srch_done = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin srch_done = 1; srch_level = 16'(lv[tg]); end
      end
      if (srch_start) begin tg = srch_target; cnt = 1 + tg % 3; end
    end
  end

  // consumer back-pressure patterns
  initial begin
    forever begin
      @(posedge clk); #1;
      case (rmode)
        1: res_ready = cyc[0];
        2: res_ready = (cyc % 3) != 0;
        default: res_ready = 1;
      endcase
    end
  end

  task automatic pulse_go();
    @(posedge clk); #1 go = 1;
    @(posedge clk); #1 go = 0;
  endtask
  task automatic wait_done();
    while (!sweep_done) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) lv[k] = 1000 + k * 200;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);                 // R1 reset state observed
    // ideal linear transfer: zero DNL/INL (R5, R6)
    rmode = 0; pulse_go(); wait_done();
    // nonuniform steps with a dip, throttled consumer (R4, R5, R6)
    for (int k = 0; k < 256; k++) lv[k] = 1000 + k * 200 + (k * 37) % 61;
    lv[120] = lv[119] - 150;
    rmode = 1; pulse_go(); wait_done();
    // saturation both ways, levels above half scale (R7, R10)
    lv[1] = 30000; lv[2] = 0;
    for (int k = 3; k < 256; k++) lv[k] = 62000 + (k - 3) * 10;
    rmode = 2; pulse_go(); wait_done();
    // degenerate span; extra go during sweep and result pass ignored (R8, R3)
    for (int k = 0; k < 256; k++) lv[k] = 5000;
    rmode = 0; pulse_go();
    repeat (100) @(posedge clk);
    pulse_go();                                 // R3: during sweep
    while (!res_valid) @(posedge clk);
    repeat (5) @(posedge clk);
    pulse_go();                                 // R3: during result pass
    wait_done();
    finish_up();
  end
endmodule